// File: doc/BRIEF.md
# Table-Driven Traffic Light Controller

This block runs a two-way junction (north-south and east-west) as a finite state machine whose entire transition and output behaviour is a constant lookup table. On every clock the current state and the east-west car sensor together form the table address. The table word gives the next state and the lamp pattern for the current state. Both fields are captured into registers, so the lamps follow the state by one cycle.

The fixed sequence gives north-south a green of at least three cycles. North-south then stays green until an east-west car is reported. East-west keeps green for as long as the sensor stays high. After either yellow, both directions show red for a single cycle before the other direction turns green. Changing the behaviour means changing only the table function. The sequencing logic does not change.

Top module: `tlc_table_ctrl`

## Requirements
- R1: `lamps[5:3]` is the north-south group and `lamps[2:0]` is the east-west group. In each group, green is 100, yellow is 010 and red is 001. Each group always shows exactly one lamp.
- R2: Reset is synchronous and active low. On a clock edge where `rst_n` is low, the state returns to the first north-south green state and `lamps` becomes 001001.
- R3: The phase order is north-south green (three states), north-south yellow, all red, east-west green, east-west yellow, all red, and then back to north-south green.
- R4: North-south green lasts at least three consecutive cycles. In its third state, the controller stays there while `car_ew` is low.
- R5: In the third north-south green state, a high `car_ew` moves the controller to north-south yellow at the next edge.
- R6: East-west green holds while `car_ew` is high. A low `car_ew` during east-west green moves the controller to east-west yellow at the next edge.
- R7: Each yellow cycle is followed by exactly one all-red cycle (001001). The opposite direction's green comes next.
- R8: The lamps are registered. A value of `car_ew` sampled at edge k first shows on `lamps` after edge k+1.
- R9: The two directions never show a non-red lamp at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| car_ew | input | 1 | East-west car sensor, high when a car waits or is present |
| lamps | output | 6 | {north-south group, east-west group}, one-hot green/yellow/red per group |

## Verification
Holding `car_ew` low for a long stretch shows that north-south green parks in its third state. Holding it high shows that east-west green persists and that the three-cycle minimum is still enforced. A sensor that toggles every cycle and a period-five pattern land edges in every state, including the single cycles at the end of green. These patterns tell a correct one-cycle lamp lag apart from an off-by-one in the table. A long pseudo-random run and a reset asserted mid-sequence show that every table word, and the return to the first green, agree with a behavioural model on each cycle.

// File: rtl/tlc_pkg.sv
// Package: shared widths, state encoding, lamp codes and the function that
// computes every word of the controller's lookup table.
// Assumes one sensor input and two three-lamp groups.
package tlc_pkg;

    localparam int STATE_W = 3;
    localparam int SENSE_W = 1;
    localparam int LAMP_W  = 3;
    localparam int GROUPS  = 2;
    localparam int OUT_W   = LAMP_W * GROUPS;
    localparam int ADDR_W  = STATE_W + SENSE_W;
    localparam int WORD_W  = STATE_W + OUT_W;

    localparam logic [LAMP_W-1:0] LAMP_GO   = 3'b100;
    localparam logic [LAMP_W-1:0] LAMP_SLOW = 3'b010;
    localparam logic [LAMP_W-1:0] LAMP_STOP = 3'b001;

    typedef enum logic [STATE_W-1:0] {
        ST_NS_GO1  = 3'd0,
        ST_NS_GO2  = 3'd1,
        ST_NS_GO3  = 3'd2,
        ST_NS_SLOW = 3'd3,
        ST_CLEAR_A = 3'd4,
        ST_EW_GO   = 3'd5,
        ST_EW_SLOW = 3'd6,
        ST_CLEAR_B = 3'd7
    } phase_t;

    // Table word for address {state, car}: {next state, ns lamps, ew lamps}
    function automatic logic [WORD_W-1:0] table_word(input logic [ADDR_W-1:0] addr);
        phase_t            cur;
        logic              car;
        phase_t            nxt;
        logic [LAMP_W-1:0] ns;
        logic [LAMP_W-1:0] ew;
        cur = phase_t'(addr[ADDR_W-1:SENSE_W]);
        car = addr[0];
        ns  = LAMP_STOP;
        ew  = LAMP_STOP;
        case (cur)
            ST_NS_GO1:  begin nxt = ST_NS_GO2; ns = LAMP_GO; end
            ST_NS_GO2:  begin nxt = ST_NS_GO3; ns = LAMP_GO; end
            ST_NS_GO3:  begin nxt = car ? ST_NS_SLOW : ST_NS_GO3; ns = LAMP_GO; end
            ST_NS_SLOW: begin nxt = ST_CLEAR_A; ns = LAMP_SLOW; end
            ST_CLEAR_A: begin nxt = ST_EW_GO; end
            ST_EW_GO:   begin nxt = car ? ST_EW_GO : ST_EW_SLOW; ew = LAMP_GO; end
            ST_EW_SLOW: begin nxt = ST_CLEAR_B; ew = LAMP_SLOW; end
            default:    begin nxt = ST_NS_GO1; end
        endcase
        return {nxt, ns, ew};
    endfunction

endpackage

// File: rtl/tlc_rom.sv
// Module: constant lookup table. Each entry is computed by the package
// function at elaboration. Assumes DEPTH = 2**ADDR_W, with read purely combinational.
module tlc_rom #(
    parameter int ADDR_W = tlc_pkg::ADDR_W,
    parameter int DATA_W = tlc_pkg::WORD_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    // Fill one entry per address from the table function
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign words[i] = tlc_pkg::table_word(ADDR_W'(i));
    end

    // Combinational read of the addressed entry
    assign data = words[addr];
endmodule

// File: rtl/tlc_reg.sv
// Module: plain register with a synchronous active-low reset to RST_VAL.
// Assumes rst_n is synchronous to clk.
module tlc_reg #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d each edge, or load the reset value
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d;
    end
endmodule

// File: rtl/tlc_table_ctrl.sv
// Module: top of the table-driven junction controller. The state register
// and the sensor address the table. The word's next-state field feeds the
// state register, and its lamp field feeds the output register.
// Assumes car_ew is already synchronous to clk.
module tlc_table_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       car_ew,
    output logic [5:0] lamps
);
    import tlc_pkg::*;

    logic [STATE_W-1:0] state_q;
    logic [ADDR_W-1:0]  rom_addr;
    logic [WORD_W-1:0]  rom_word;
    logic [STATE_W-1:0] next_state;
    logic [OUT_W-1:0]   lamp_d;

    // Address the table with {current state, sensor}
    assign rom_addr = {state_q, car_ew};

    // Split the table word into its two fields
    assign {next_state, lamp_d} = rom_word;

    tlc_rom #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) i_rom (
        .addr (rom_addr),
        .data (rom_word)
    );

    tlc_reg #(.W(STATE_W), .RST_VAL(STATE_W'(ST_NS_GO1))) i_state_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (next_state),
        .q     (state_q)
    );

    tlc_reg #(.W(OUT_W), .RST_VAL({LAMP_STOP, LAMP_STOP})) i_lamp_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lamp_d),
        .q     (lamps)
    );
endmodule

// File: rtl/tlc_table_ctrl_chk.sv
// Module: property checker for the junction controller. It is bound into
// tlc_table_ctrl and observes its ports and state register.
module tlc_table_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       car_ew,
    input logic [2:0] state_q,
    input logic [5:0] lamps
);
    import tlc_pkg::*;

    logic ns_green, ns_yel, ew_yel;
    assign ns_green = (lamps[5:3] == LAMP_GO);
    assign ns_yel   = (lamps[5:3] == LAMP_SLOW);
    assign ew_yel   = (lamps[2:0] == LAMP_SLOW);

    AST_GROUP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(lamps[5:3]) && $onehot(lamps[2:0])); // R1
    AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        (lamps[5:3] == LAMP_STOP) || (lamps[2:0] == LAMP_STOP)); // R9
    AST_RED_AFTER_YELLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ns_yel || ew_yel) |=> (lamps == {LAMP_STOP, LAMP_STOP})); // R7
    AST_RED_GAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (lamps == {LAMP_STOP, LAMP_STOP}) && $past(ns_yel || ew_yel)
        |=> (lamps != {LAMP_STOP, LAMP_STOP})); // R7
    AST_NS_MIN_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ns_green) |=> ns_green ##1 ns_green); // R4
    AST_NS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NS_GO3) && !car_ew |=> (state_q == ST_NS_GO3)); // R4
    AST_NS_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NS_GO3) && car_ew |=> (state_q == ST_NS_SLOW)); // R5
    AST_EW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EW_GO) && car_ew |=> (state_q == ST_EW_GO)); // R6
    AST_LAMP_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NS_SLOW) |=> ns_yel); // R8
endmodule

bind tlc_table_ctrl tlc_table_ctrl_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .car_ew  (car_ew),
    .state_q (state_q),
    .lamps   (lamps)
);

// File: tb/test_tlc_table_ctrl.sv
// Bench: a behavioural junction model, stepped on each rising edge and
// compared with lamps on each falling edge.
module test_tlc_table_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       car_ew = 1'b0;
    logic [5:0] lamps;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    m_phase = 0;
    int    ns_run = 0;
    bit    armed = 1'b0;
    logic [5:0] exp_lamps = 6'b001001;
    string exp_tag = "R2";

    always #4 clk = ~clk;

    tlc_table_ctrl i_tlc_table_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .car_ew (car_ew),
        .lamps  (lamps)
    );

    // Phase index: 0..2 ns green, 3 ns yellow, 4 red, 5 ew green, 6 ew yellow, 7 red
    function automatic logic [5:0] show(int p);
        if (p <= 2) return 6'b100001;
        if (p == 3) return 6'b010001;
        if (p == 5) return 6'b001100;
        if (p == 6) return 6'b001010;
        return 6'b001001;
    endfunction

    function automatic int advance(int p, bit car);
        if (p == 2) return car ? 3 : 2;
        if (p == 5) return car ? 5 : 6;
        return (p + 1) % 8;
    endfunction

    function automatic string tag_of(int p);
        if (p == 2) return "R4 R5 R8";
        if (p == 5) return "R6 R8";
        if (p == 3 || p == 6 || p == 4 || p == 7) return "R7";
        return "R3";
    endfunction

    task automatic check(bit ok, string req, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: lamps actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Reference model step at the rising edge
    always @(posedge clk) begin
        cyc++;
        armed = 1'b1;
        if (!rst_n) begin
            exp_lamps = 6'b001001;
            exp_tag   = "R2";
            m_phase   = 0;
        end else begin
            exp_lamps = show(m_phase);
            exp_tag   = tag_of(m_phase);
            m_phase   = advance(m_phase, car_ew);
        end
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R3 watchdog: cycle %0d expected below 20000", cyc);
            finish_run();
        end
    end

    // Compare lamps away from the edge; also the safety and min-green checks
    always @(negedge clk) begin
        if (armed) begin
            check(lamps === exp_lamps, exp_tag, lamps, exp_lamps);
            check(lamps[5:3] == 3'b001 || lamps[2:0] == 3'b001, "R9 R1", lamps, 6'b001001);
            if (!rst_n) ns_run = 0;
            else if (lamps[5:3] == 3'b100) ns_run++;
            else begin
                if (ns_run > 0)
                    check(ns_run >= 3, "R4 min-green", 6'(ns_run), 6'd3);
                ns_run = 0;
            end
        end
    end

    task automatic drive(bit car, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            car_ew = car;
        end
    endtask

    initial begin
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        drive(1'b0, 3);                 // R2 reset held
        @(negedge clk); #1; rst_n = 1'b1;
        drive(1'b0, 40);                // R4 parked in ns green
        drive(1'b1, 30);                // R5 R6 ew green held
        for (int i = 0; i < 60; i++) drive(i[0], 1);          // R7 toggling
        for (int i = 0; i < 100; i++) drive((i % 5) < 2, 1);  // R8 period five
        for (int i = 0; i < 1000; i++) begin                  // R3 random
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[0], 1);
        end
        drive(1'b1, 7);
        @(negedge clk); #1; rst_n = 1'b0;   // R2 mid-run reset
        drive(1'b1, 2);
        @(negedge clk); #1; rst_n = 1'b1;
        drive(1'b1, 50);
        drive(1'b0, 3);
        finish_run();
    end
endmodule